// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block holds a small set of recent virtual-to-physical page translations for 4 KB pages. Each 32-bit request address is split into a 20-bit virtual page number and a 12-bit page offset. The page number is compared against every stored entry in parallel. A match that the entry's permissions allow returns the physical address in the same cycle. A match that the permissions deny reports a protection fault instead.

When no entry matches, the block reports a miss and presents the page number to an external page table walker. The walker later returns a complete entry on the fill port, and the block installs it at the next clock edge. Pages not yet present are placed by a first-in first-out victim pointer. A fill for a page that is already present rewrites that entry in place.

Entries carry no program identifier. A flush input therefore empties the whole buffer on a context switch. With the default 16 entries the buffer maps up to 64 KB of contiguous space. At 64 entries it would map 256 KB.

Top module: `tlb_fa`

## Requirements
- R1: After reset, no entry is valid, so every valid request reports a miss.
- R2: On a permitted match, hit_o is 1 in the same cycle. paddr_o equals {stored physical page number, req_vaddr_i[11:0]}, where the page number occupies bits 31:12.
- R3: On a valid request that matches no entry, miss_o is 1 and walk_vpn_o equals req_vaddr_i[31:12] in the same cycle. When req_valid_i is 0, hit_o, fault_o, miss_o and dirty_o are all 0, and both paddr_o and walk_vpn_o are 0.
- R4: An entry presented on the fill port with fill_valid_i = 1 is used by lookups from the next cycle on. The entry has these fields: page number, physical page number, read bit, write bit and dirty bit.
- R5: Fills for pages not already present go to slots 0, 1, ... ENTRIES-1 and then wrap back to slot 0. Once the buffer is full, each new page evicts the oldest one installed.
- R6: A fill whose page number matches a valid entry overwrites that entry. It does not move the victim pointer, so at most one entry ever matches a page number.
- R7: A load (req_store_i = 0) needs the read bit and a store (req_store_i = 1) needs the write bit. A denied match sets fault_o = 1 and hit_o = 0, and paddr_o is 0. On a valid request, exactly one of hit_o, fault_o and miss_o is 1.
- R8: dirty_o shows the dirty bit of the matched entry when there is a match. A permitted store to an entry whose dirty bit is clear sets that bit at the clock edge. In the same cycle a fill to the same entry takes precedence.
- R9: With flush_i = 1, every entry becomes invalid at the clock edge and the victim pointer returns to slot 0. A fill in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Lookup request present |
| req_vaddr_i | input | 32 | Virtual address |
| req_store_i | input | 1 | 1 for store, 0 for load |
| hit_o | output | 1 | Permitted translation found |
| fault_o | output | 1 | Match with permission denied |
| miss_o | output | 1 | No matching entry |
| dirty_o | output | 1 | Dirty bit of the matched entry |
| paddr_o | output | 32 | Translated physical address |
| walk_vpn_o | output | 20 | Page number for the walker on a miss |
| fill_valid_i | input | 1 | Install fill entry |
| fill_vpn_i | input | 20 | Fill virtual page number |
| fill_ppn_i | input | 20 | Fill physical page number |
| fill_rd_i | input | 1 | Fill read permission |
| fill_wr_i | input | 1 | Fill write permission |
| fill_dirty_i | input | 1 | Fill dirty bit |

## Verification
A corrupted entry or a slip in the victim pointer stays hidden until that page is looked up again. It then shows as a wrong physical address, a flipped hit/fault outcome, or a page that was evicted too early or too late. The bench therefore keeps a full copy of the table and compares all outputs on every request, so a divergence is reported on the first lookup that touches the affected slot. Random traffic over a page pool larger than the table forces evictions, refills of pages already present, and stores to clean entries. These are the paths where a wrong pointer step or a missed dirty update would first show.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = 20;
  localparam int PA_W  = PPN_W + OFF_W;

  typedef logic [VPN_W-1:0] vpn_t;
  typedef logic [PPN_W-1:0] ppn_t;

  typedef struct packed {
    logic valid;
    logic rd;
    logic wr;
    logic dirty;
    vpn_t vpn;
    ppn_t ppn;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  tlb_entry_t       ent_i [ENTRIES],
  input  vpn_t             vpn_i,
  output logic [ENTRIES-1:0] match_o,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = ent_i[g].valid && (ent_i[g].vpn == vpn_i);
  end

  assign any_o = |match_o;

  // OR-encode; valid only because matches are unique
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match_o[i]) idx_o = idx_o | IDX_W'(i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_o <= '0;
    else if (flush_i) ptr_o <= '0;
    else if (adv_i)   ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

  p_ptr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !flush_i && ptr_o != LAST) |=> ptr_o == $past(ptr_o) + 1'b1);

  p_ptr_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !flush_i && ptr_o == LAST) |=> ptr_o == '0);

  p_ptr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !flush_i) |=> $stable(ptr_o));

  p_ptr_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> ptr_o == '0);
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flush_i,
  input  logic        req_valid_i,
  input  logic [31:0] req_vaddr_i,
  input  logic        req_store_i,
  output logic        hit_o,
  output logic        fault_o,
  output logic        miss_o,
  output logic        dirty_o,
  output logic [31:0] paddr_o,
  output logic [19:0] walk_vpn_o,
  input  logic        fill_valid_i,
  input  logic [19:0] fill_vpn_i,
  input  logic [19:0] fill_ppn_i,
  input  logic        fill_rd_i,
  input  logic        fill_wr_i,
  input  logic        fill_dirty_i
);
  localparam int IDX_W = $clog2(ENTRIES);

  tlb_entry_t ent_q [ENTRIES];

  vpn_t                 req_vpn;
  logic [OFF_W-1:0]     req_off;
  logic [ENTRIES-1:0]   look_match, fill_match;
  logic                 look_any, fill_any;
  logic [IDX_W-1:0]     look_idx, fill_idx, victim_ptr, fill_slot;
  tlb_entry_t           sel;
  logic                 perm_ok, fill_new, set_dirty;

  assign req_vpn = req_vaddr_i[VA_W-1:OFF_W];
  assign req_off = req_vaddr_i[OFF_W-1:0];

  tlb_match #(.ENTRIES(ENTRIES)) u_look (
    .ent_i(ent_q), .vpn_i(req_vpn),
    .match_o(look_match), .any_o(look_any), .idx_o(look_idx)
  );

  tlb_match #(.ENTRIES(ENTRIES)) u_fill (
    .ent_i(ent_q), .vpn_i(fill_vpn_i),
    .match_o(fill_match), .any_o(fill_any), .idx_o(fill_idx)
  );

  assign fill_new  = fill_valid_i && !flush_i && !fill_any;
  assign fill_slot = fill_any ? fill_idx : victim_ptr;

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .adv_i(fill_new), .ptr_o(victim_ptr)
  );

  assign sel     = ent_q[look_idx];
  assign perm_ok = req_store_i ? sel.wr : sel.rd;

  assign hit_o      = req_valid_i && look_any && perm_ok;
  assign fault_o    = req_valid_i && look_any && !perm_ok;
  assign miss_o     = req_valid_i && !look_any;
  assign dirty_o    = req_valid_i && look_any && sel.dirty;
  assign paddr_o    = hit_o ? {sel.ppn, req_off} : '0;
  assign walk_vpn_o = miss_o ? req_vpn : '0;

  assign set_dirty = hit_o && req_store_i && !sel.dirty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i].valid <= 1'b0;
    end else begin
      if (set_dirty) ent_q[look_idx].dirty <= 1'b1;
      // fill written last so it wins on a shared slot
      if (fill_valid_i)
        ent_q[fill_slot] <= '{valid: 1'b1, rd: fill_rd_i, wr: fill_wr_i,
                              dirty: fill_dirty_i, vpn: fill_vpn_i,
                              ppn: fill_ppn_i};
    end
  end

  p_unique_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(look_match));

  p_one_outcome_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $countones({hit_o, fault_o, miss_o}) == 1);

  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(hit_o || fault_o || miss_o || dirty_o));

  p_fault_no_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> paddr_o == '0);

  p_flush_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !(hit_o || fault_o || dirty_o));

  p_fill_visible_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i && req_valid_i && fill_vpn_i == req_vpn) |=>
    (req_valid_i && $stable(req_vaddr_i)) |-> !miss_o);
endmodule

// File: tb/tb_tlb_fa.sv
module tb_tlb_fa;
  localparam int ENTRIES = 16;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0, req_valid_i = 1'b0, req_store_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic        fill_valid_i = 1'b0, fill_rd_i = 1'b0, fill_wr_i = 1'b0, fill_dirty_i = 1'b0;
  logic [19:0] fill_vpn_i = '0, fill_ppn_i = '0;
  logic        hit_o, fault_o, miss_o, dirty_o;
  logic [31:0] paddr_o;
  logic [19:0] walk_vpn_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_fa #(.ENTRIES(ENTRIES)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .req_valid_i(req_valid_i), .req_vaddr_i(req_vaddr_i), .req_store_i(req_store_i),
    .hit_o(hit_o), .fault_o(fault_o), .miss_o(miss_o), .dirty_o(dirty_o),
    .paddr_o(paddr_o), .walk_vpn_o(walk_vpn_o),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_ppn_i(fill_ppn_i),
    .fill_rd_i(fill_rd_i), .fill_wr_i(fill_wr_i), .fill_dirty_i(fill_dirty_i)
  );

  // reference table
  logic        m_v [ENTRIES], m_rd [ENTRIES], m_wr [ENTRIES], m_d [ENTRIES];
  logic [19:0] m_vpn [ENTRIES], m_ppn [ENTRIES];
  int          m_ptr;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int find(logic [19:0] vpn);
    for (int i = 0; i < ENTRIES; i++)
      if (m_v[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < ENTRIES; i++) begin
      m_v[i] = 0; m_rd[i] = 0; m_wr[i] = 0; m_d[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0;
    end
    m_ptr = 0;
  endtask

  // drive one cycle, check combinational outputs, then advance model
  task automatic step(string tag, bit rv, logic [31:0] va, bit st, bit fl,
                      bit fv, logic [19:0] fvpn, logic [19:0] fppn,
                      bit frd, bit fwr, bit fd);
    int m, f;
    bit e_hit, e_fault, e_miss, e_dirty, ok;
    logic [31:0] e_pa;
    logic [19:0] e_walk;
    @(negedge clk);
    req_valid_i = rv; req_vaddr_i = va; req_store_i = st; flush_i = fl;
    fill_valid_i = fv; fill_vpn_i = fvpn; fill_ppn_i = fppn;
    fill_rd_i = frd; fill_wr_i = fwr; fill_dirty_i = fd;
    #1;
    m = find(va[31:12]);
    ok = (m >= 0) && (st ? m_wr[m] : m_rd[m]);
    e_hit   = rv && m >= 0 && ok;
    e_fault = rv && m >= 0 && !ok;
    e_miss  = rv && m < 0;
    e_dirty = rv && m >= 0 && m_d[m];
    e_pa    = e_hit ? {m_ppn[m], va[11:0]} : 32'h0;
    e_walk  = e_miss ? va[31:12] : 20'h0;
    chk({tag, " hit"},   32'(hit_o),   32'(e_hit));
    chk({tag, " fault"}, 32'(fault_o), 32'(e_fault));
    chk({tag, " miss"},  32'(miss_o),  32'(e_miss));
    chk({tag, " dirty"}, 32'(dirty_o), 32'(e_dirty));
    chk({tag, " paddr"}, paddr_o, e_pa);
    chk({tag, " walk"},  32'(walk_vpn_o), 32'(e_walk));
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < ENTRIES; i++) m_v[i] = 0;
      m_ptr = 0;
    end else begin
      if (e_hit && st && !m_d[m]) m_d[m] = 1;
      if (fv) begin
        f = find(fvpn);
        if (f < 0) begin
          f = m_ptr;
          m_ptr = (m_ptr + 1) % ENTRIES;
        end
        m_v[f] = 1; m_vpn[f] = fvpn; m_ppn[f] = fppn;
        m_rd[f] = frd; m_wr[f] = fwr; m_d[f] = fd;
      end
    end
  endtask

  task automatic look(string tag, logic [31:0] va, bit st);
    step(tag, 1, va, st, 0, 0, '0, '0, 0, 0, 0);
  endtask

  task automatic fill(string tag, logic [19:0] vpn, logic [19:0] ppn, bit rd, bit wr, bit d);
    step(tag, 0, '0, 0, 0, 1, vpn, ppn, rd, wr, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 / R3: empty after reset, miss presents page number
    look("R1 reset miss", 32'h1234_5678, 0);
    step("R3 idle", 0, 32'hFFFF_F000, 0, 0, 0, '0, '0, 0, 0, 0);
    chk("R3 idle miss port", 32'(miss_o), 32'h0);

    // R4 / R2: install and hit with offset passthrough
    fill("R4 fill", 20'h00010, 20'hABCDE, 1, 0, 0);
    look("R2 load hit", 32'h0001_0ABC, 0);
    chk("R2 paddr direct", paddr_o, 32'hABCD_EABC);
    // R7: store without write bit faults
    look("R7 store fault", 32'h0001_0004, 1);
    chk("R7 fault direct", 32'(fault_o), 32'h1);

    // R8: permitted store to clean entry sets dirty
    fill("R8 fill rw", 20'h00020, 20'h00777, 1, 1, 0);
    look("R8 first store", 32'h0002_0010, 1);
    look("R8 dirty seen", 32'h0002_0010, 0);
    chk("R8 dirty direct", 32'(dirty_o), 32'h1);

    // R7: write-only entry refuses loads
    fill("R7 fill wo", 20'h00030, 20'h00333, 0, 1, 0);
    look("R7 load fault", 32'h0003_0000, 0);

    // R6: refill of present page overwrites in place
    fill("R6 refill", 20'h00010, 20'h11111, 1, 1, 1);
    look("R6 new ppn", 32'h0001_0020, 0);
    chk("R6 paddr direct", paddr_o, 32'h1111_1020);

    // R5: fill past capacity evicts oldest in order
    for (int i = 0; i < ENTRIES; i++)
      fill("R5 fill", 20'h00100 + 20'(i), 20'h20000 + 20'(i), 1, 1, 0);
    look("R5 evict oldest", 32'h0001_0000, 0);
    look("R5 evict second", 32'h0002_0000, 0);
    look("R5 third evicted", 32'h0003_0000, 0);
    look("R5 kept", 32'h0010_0000, 0);
    look("R5 last kept", 32'h0010_F000, 0);
    chk("R5 last hit direct", 32'(hit_o), 32'h1);

    // R9: flush with simultaneous fill drops both
    step("R9 flush+fill", 0, '0, 0, 1, 1, 20'h00500, 20'h00555, 1, 1, 0);
    look("R9 flushed", 32'h0010_0000, 0);
    look("R9 fill dropped", 32'h0050_0000, 0);
    chk("R9 miss direct", 32'(miss_o), 32'h1);
    fill("R9 ptr to 0", 20'h00600, 20'h00666, 1, 0, 0);
    look("R9 after flush", 32'h0060_0000, 0);

    // random mix over a pool larger than the table
    s = $urandom(32'd7);
    for (int n = 0; n < 4000; n++) begin
      logic [19:0] pv;
      pv = 20'($urandom_range(0, 27));
      step("R2 R4 R5 R6 R7 R8 rand", ($urandom_range(0, 3) != 0),
           {pv, 12'($urandom)}, $urandom_range(0, 1), ($urandom_range(0, 199) == 0),
           ($urandom_range(0, 2) == 0), 20'($urandom_range(0, 27)), 20'($urandom),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule